// File: doc/BRIEF.md
# Synchronous Receive Hunter with Character Stripping

This block is the receive front end of a character-oriented synchronous link that runs on a 1x bit clock. Every rising edge of `clk` delivers one serial bit on `rx_bit`, least significant bit first. When `rx_en` goes high, the block searches the bit stream one bit at a time for the programmed sync character. Once it has locked, it cuts the stream into characters at fixed boundaries and hands each character over as a one-cycle `rx_valid` strobe with `rx_data`.

Three framing modes are available. In single-sync mode one sync character gives lock. In double-sync mode the first sync character must be followed by a second, different one. In transparent mode a link-escape character protects the sync codes. Instead of the internal search, an external strobe can set the character boundary. Two status flags report sync sequences and escape sequences. An optional filter removes fill and escape characters before they are delivered.

Top module: `sync_rx_hunter`

## Requirements
- R1: On the cycle `rx_en` is first sampled high, the block enters the hunt state. From then on it compares the last L received bits against `syn1` at every bit position, so lock can occur at any bit offset.
- R2: With `dbl_syn`=0 and `jam_mode`=0, a `syn1` match gives lock and sets `syn_det`. With `dbl_syn`=1, the next L-bit character must equal `syn2`, otherwise the search resumes. The stream `syn1`,`syn1`,`syn2` does not give lock.
- R3: Characters consumed to gain lock are never delivered. After lock, each group of L bits becomes one character: the first received bit is bit 0, and the character is shown on `rx_data` for one cycle with `rx_valid`=1.
- R4: With `strip_en`=1 and `transp`=0, characters equal to `syn1` are dropped. In double-sync mode a `syn2` is also dropped, but only when it directly follows a `syn1`. A `syn2` on its own is delivered.
- R5: With `strip_en`=1 and `transp`=1, an escape character (`dle`) is dropped, and a `syn1` directly after an escape is dropped. In an escape-escape pair only the first is dropped.
- R6: After lock, `syn_det` sets again on each further sync sequence. In transparent mode that sequence is escape followed by `syn1`. A `status_rd` pulse clears `syn_det` unless a set happens in the same cycle.
- R7: In transparent mode, `dle_det` sets when a character follows an escape and equals neither `syn2` nor `dle`. It clears when the next character completes or when the receiver is disabled.
- R8: The `strip_en` setting has no effect on `syn_det` or `dle_det`.
- R9: With `jam_mode`=1, pattern matching never gives lock or sets `syn_det`. A 0-to-1 change of `ext_sync` sampled at an edge gives lock and sets `syn_det`. The bit sampled at the following edge is bit 0 of the next character, and `syn_det` holds until `status_rd`.
- R10: `len_sel` 0..3 selects L = 5..8 bits. Comparisons use only the low L bits of `syn1`, `syn2` and `dle`, and the unused high bits of `rx_data` read zero.
- R11: While `rx_en` is low, nothing is delivered, and one edge later `syn_det` and `dle_det` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1x receive bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; rising edge starts the hunt |
| rx_bit | input | 1 | Serial data, sampled on rising edge |
| syn1 | input | 8 | First sync character |
| syn2 | input | 8 | Second sync character |
| dle | input | 8 | Escape character |
| len_sel | input | 2 | Character length, L = 5 + len_sel |
| dbl_syn | input | 1 | 1 = two-character sync sequence |
| transp | input | 1 | 1 = transparent (escape) mode |
| strip_en | input | 1 | 1 = drop fill and escape characters |
| jam_mode | input | 1 | 1 = boundary set by `ext_sync` |
| ext_sync | input | 1 | External sync strobe |
| status_rd | input | 1 | Status read strobe, clears `syn_det` |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| syn_det | output | 1 | Sync sequence seen |
| dle_det | output | 1 | Escape followed by data seen |

## Verification
The bench feeds a `syn1`,`syn1`,`syn2` stream. A design that kept testing the current window on falling back to the hunt would lock on it and deliver the trailing idle bits. It sends a lone `syn2` and an escape-escape pair. A filter that ignores the preceding character would drop a real data byte or swallow both escapes. It repeats the escape sequences with stripping off. Flags that were gated by the filter would then fail to set. It also checks 5-bit characters against a `syn1` whose upper bits are set. A full-width comparison would never lock there. Finally it checks that in jam mode an embedded sync pattern is ignored and that the bit after the strobe starts the character.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HUNT  = 2'd1,
      ST_WAIT2 = 2'd2,
      ST_SYNC  = 2'd3
   } rxh_state_e;

endpackage

// File: rtl/rxh_window.sv
module rxh_window #(
   parameter int CHAR_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_i,
   input  logic [CNT_W-1:0]  cur_len,
   input  logic [CHAR_W-1:0] pat1,
   input  logic [CHAR_W-1:0] pat2,
   input  logic [CHAR_W-1:0] pat_esc,
   output logic [CHAR_W-1:0] nchar,
   output logic              eq_p1,
   output logic              eq_p2,
   output logic              eq_esc
);

   logic [CHAR_W-1:0] sr_q;
   logic [CHAR_W-1:0] sr_n;
   logic [CHAR_W-1:0] mask;
   logic [CNT_W-1:0]  shamt;

   // newest bit enters at the top; the oldest of the last L bits lands at bit 0
   assign sr_n  = {bit_i, sr_q[CHAR_W-1:1]};
   assign shamt = CNT_W'(CHAR_W) - cur_len;
   assign nchar = sr_n >> shamt;
   assign mask  = ~({CHAR_W{1'b1}} << cur_len);

   assign eq_p1  = (nchar == (pat1 & mask));
   assign eq_p2  = (nchar == (pat2 & mask));
   assign eq_esc = (nchar == (pat_esc & mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '1;
      else        sr_q <= sr_n;
   end

endmodule

// File: rtl/rxh_framer.sv
module rxh_framer
   import rxh_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             jam_mode,
   input  logic             ext_sync,
   input  logic             dbl,
   input  logic [CNT_W-1:0] cur_len,
   input  logic             eq_p1,
   input  logic             eq_p2,
   output logic             char_done,
   output logic             sync_gain
);

   rxh_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             en_q, ext_q;
   logic [CNT_W-1:0] lim;
   logic             last, ext_rise, live;

   assign lim      = cur_len - CNT_W'(1);
   assign last     = (cnt_q >= lim);
   assign live     = en && en_q;
   assign ext_rise = live && jam_mode && ext_sync && !ext_q;

   always_comb begin
      char_done = live && !ext_rise && (st_q == ST_SYNC) && last;
      sync_gain = ext_rise;
      if (live && !jam_mode) begin
         if (st_q == ST_HUNT && last && eq_p1 && !dbl) sync_gain = 1'b1;
         if (st_q == ST_WAIT2 && last && eq_p2)        sync_gain = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         en_q  <= 1'b0;
         ext_q <= 1'b0;
      end else begin
         en_q  <= en;
         ext_q <= ext_sync;
         if (!en) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
         end else if (!en_q) begin
            st_q  <= ST_HUNT;
            cnt_q <= CNT_W'(1);
         end else if (ext_rise) begin
            st_q  <= ST_SYNC;
            cnt_q <= '0;
         end else begin
            unique case (st_q)
               ST_HUNT: begin
                  if (!jam_mode && last && eq_p1) begin
                     st_q  <= dbl ? ST_WAIT2 : ST_SYNC;
                     cnt_q <= '0;
                  end else if (!last) begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               ST_WAIT2: begin
                  if (last) begin
                     // a failed second character resumes the hunt on the next bit only
                     st_q  <= eq_p2 ? ST_SYNC : ST_HUNT;
                     cnt_q <= eq_p2 ? '0 : cur_len;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               ST_SYNC: cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
               default: st_q <= ST_HUNT;
            endcase
         end
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SYNC) |-> (cnt_q < CNT_W'(CHAR_W))); // R3

endmodule

// File: rtl/rxh_filter.sv
module rxh_filter #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              transp,
   input  logic              dbl,
   input  logic              strip,
   input  logic              jam_mode,
   input  logic              char_done,
   input  logic              sync_gain,
   input  logic              status_rd,
   input  logic              eq_p1,
   input  logic              eq_p2,
   input  logic              eq_esc,
   input  logic [CHAR_W-1:0] nchar,
   output logic [CHAR_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              syn_det,
   output logic              dle_det
);

   logic prev_p1_q, esc_pend_q;
   logic drop, syn_hit, esc_hit;

   always_comb begin
      if (transp) begin
         drop    = (eq_esc && !esc_pend_q) || (eq_p1 && esc_pend_q);
         syn_hit = esc_pend_q && eq_p1;
      end else begin
         drop    = eq_p1 || (dbl && eq_p2 && prev_p1_q);
         syn_hit = dbl ? (prev_p1_q && eq_p2) : eq_p1;
      end
      drop    = drop && strip;
      syn_hit = syn_hit && !jam_mode;
      esc_hit = transp && esc_pend_q && !eq_p2 && !eq_esc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data    <= '0;
         rx_valid   <= 1'b0;
         syn_det    <= 1'b0;
         dle_det    <= 1'b0;
         prev_p1_q  <= 1'b0;
         esc_pend_q <= 1'b0;
      end else if (!en) begin
         rx_valid   <= 1'b0;
         syn_det    <= 1'b0;
         dle_det    <= 1'b0;
         prev_p1_q  <= 1'b0;
         esc_pend_q <= 1'b0;
      end else begin
         rx_valid <= char_done && !drop;
         if (char_done && !drop) rx_data <= nchar;
         if (sync_gain) begin
            prev_p1_q  <= 1'b0;
            esc_pend_q <= 1'b0;
         end else if (char_done) begin
            prev_p1_q  <= eq_p1;
            esc_pend_q <= transp && eq_esc && !esc_pend_q;
            dle_det    <= esc_hit;
         end
         if (sync_gain || (char_done && syn_hit)) syn_det <= 1'b1;
         else if (status_rd)                      syn_det <= 1'b0;
      end
   end

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!rx_valid && !syn_det && !dle_det)); // R11
   AST_ESC_FLAG_TRANSP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dle_det) |-> $past(transp)); // R7

endmodule

// File: rtl/sync_rx_hunter.sv
module sync_rx_hunter #(
   parameter int CHAR_W = 8,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_bit,
   input  logic [CHAR_W-1:0] syn1,
   input  logic [CHAR_W-1:0] syn2,
   input  logic [CHAR_W-1:0] dle,
   input  logic [LEN_W-1:0]  len_sel,
   input  logic              dbl_syn,
   input  logic              transp,
   input  logic              strip_en,
   input  logic              jam_mode,
   input  logic              ext_sync,
   input  logic              status_rd,
   output logic [CHAR_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              syn_det,
   output logic              dle_det
);

   localparam int CNT_W   = $clog2(CHAR_W + 1) + 1;
   localparam int MIN_LEN = CHAR_W - (1 << LEN_W) + 1;

   if (MIN_LEN < 1) begin : g_bad_len
      $error("sync_rx_hunter: LEN_W too wide for CHAR_W");
   end

   logic [CNT_W-1:0]  cur_len;
   logic [CHAR_W-1:0] nchar;
   logic              eq_p1, eq_p2, eq_esc, char_done, sync_gain;

   assign cur_len = CNT_W'(MIN_LEN) + CNT_W'(len_sel);

   rxh_window #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .bit_i(rx_bit), .cur_len(cur_len),
      .pat1(syn1), .pat2(syn2), .pat_esc(dle),
      .nchar(nchar), .eq_p1(eq_p1), .eq_p2(eq_p2), .eq_esc(eq_esc));

   rxh_framer #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_frm (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .jam_mode(jam_mode),
      .ext_sync(ext_sync), .dbl(dbl_syn), .cur_len(cur_len),
      .eq_p1(eq_p1), .eq_p2(eq_p2),
      .char_done(char_done), .sync_gain(sync_gain));

   rxh_filter #(.CHAR_W(CHAR_W)) u_flt (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .transp(transp), .dbl(dbl_syn),
      .strip(strip_en), .jam_mode(jam_mode), .char_done(char_done),
      .sync_gain(sync_gain), .status_rd(status_rd),
      .eq_p1(eq_p1), .eq_p2(eq_p2), .eq_esc(eq_esc), .nchar(nchar),
      .rx_data(rx_data), .rx_valid(rx_valid), .syn_det(syn_det), .dle_det(dle_det));

   AST_SYNC_CHARS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      sync_gain |=> !rx_valid); // R3
   AST_GAIN_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      sync_gain |=> syn_det); // R2
   AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && status_rd && !sync_gain && !char_done) |=> !syn_det); // R6

endmodule

// File: tb/sync_rx_hunter_bench.sv
`timescale 1ns/1ps
module sync_rx_hunter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0, rx_bit = 1'b1;
   logic [7:0] syn1 = 8'h16, syn2 = 8'h32, dle = 8'h10;
   logic [1:0] len_sel = 2'd3;
   logic       dbl_syn = 1'b0, transp = 1'b0, strip_en = 1'b0, jam_mode = 1'b0;
   logic       ext_sync = 1'b0, status_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid, syn_det, dle_det;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];

   always #2.5 clk = ~clk;

   sync_rx_hunter u_sync_rx_hunter (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
      .syn1(syn1), .syn2(syn2), .dle(dle), .len_sel(len_sel),
      .dbl_syn(dbl_syn), .transp(transp), .strip_en(strip_en),
      .jam_mode(jam_mode), .ext_sync(ext_sync), .status_rd(status_rd),
      .rx_data(rx_data), .rx_valid(rx_valid), .syn_det(syn_det), .dle_det(dle_det));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R3 unexpected char", rx_data, 0);
         else begin
            automatic logic [7:0] e = exp_q.pop_front();
            chk(rx_data == e, "R3 char", rx_data, e);
         end
      end
   end

   task automatic send_char(input logic [7:0] c, input int n, input bit rd);
      for (int i = 0; i < n; i++) begin
         rx_bit    = c[i];
         status_rd = rd && (i == 0);
         @(negedge clk);
      end
      status_rd = 1'b0;
   endtask

   task automatic expect_char(input logic [7:0] c, input int n, input bit rd);
      exp_q.push_back(c);
      send_char(c, n, rd);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         rx_bit = 1'b1;
         @(negedge clk);
      end
   endtask

   task automatic restart(input bit d, input bit t, input bit s, input bit j);
      rx_en = 1'b0;
      idle(2);
      dbl_syn = d; transp = t; strip_en = s; jam_mode = j;
      rx_en = 1'b1;
   endtask

   task automatic drain(input string req);
      idle(2);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(rx_valid == 0 && syn_det == 0 && dle_det == 0, "reset", {rx_valid, syn_det, dle_det}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2 single sync at an odd bit offset, no stripping
      restart(0, 0, 0, 0);
      idle(11);
      send_char(8'h16, 8, 0);
      chk(syn_det == 1, "R1 R2 single lock", syn_det, 1);
      expect_char(8'h41, 8, 1);
      chk(syn_det == 0, "R6 status clears", syn_det, 0);
      expect_char(8'h16, 8, 0);
      chk(syn_det == 1, "R6 later sync sets", syn_det, 1);
      expect_char(8'h42, 8, 0);
      drain("R3 all delivered");
      rx_en = 1'b0;
      @(negedge clk);
      chk(syn_det == 0, "R11 disable clears", syn_det, 0);

      // R4 single strip
      restart(0, 0, 1, 0);
      idle(8);
      send_char(8'h16, 8, 0);
      expect_char(8'h41, 8, 0);
      send_char(8'h16, 8, 0);
      expect_char(8'h42, 8, 0);
      drain("R4 single strip");

      // R2/R4 double strip
      restart(1, 0, 1, 0);
      idle(8);
      send_char(8'h16, 8, 0);
      send_char(8'h32, 8, 0);
      chk(syn_det == 1, "R2 double lock", syn_det, 1);
      expect_char(8'h41, 8, 1);
      expect_char(8'h32, 8, 0);
      chk(syn_det == 0, "R6 lone syn2 no flag", syn_det, 0);
      send_char(8'h16, 8, 0);
      send_char(8'h32, 8, 0);
      chk(syn_det == 1, "R6 double sequence flag", syn_det, 1);
      expect_char(8'h43, 8, 0);
      drain("R4 double strip");

      // R2 syn1 syn1 syn2 does not lock
      restart(1, 0, 0, 0);
      idle(8);
      send_char(8'h16, 8, 0);
      send_char(8'h16, 8, 0);
      send_char(8'h32, 8, 0);
      idle(24);
      chk(syn_det == 0, "R2 no lock on syn1 syn1 syn2", syn_det, 0);
      drain("R2 no delivery");

      // R5/R7 transparent strip
      restart(1, 1, 1, 0);
      idle(8);
      send_char(8'h16, 8, 0);
      send_char(8'h32, 8, 0);
      chk(syn_det == 1, "R6 transparent initial", syn_det, 1);
      send_char(8'h10, 8, 1);
      send_char(8'h16, 8, 0);
      chk(syn_det == 1, "R6 escape-syn1 flag", syn_det, 1);
      send_char(8'h10, 8, 0);
      expect_char(8'h10, 8, 0);
      chk(dle_det == 0, "R7 escape pair no flag", dle_det, 0);
      send_char(8'h10, 8, 0);
      expect_char(8'h41, 8, 0);
      chk(dle_det == 1, "R7 escape data flag", dle_det, 1);
      expect_char(8'h42, 8, 0);
      chk(dle_det == 0, "R7 flag clears", dle_det, 0);
      drain("R5 transparent strip");

      // R8 same sequences without stripping
      restart(1, 1, 0, 0);
      idle(8);
      send_char(8'h16, 8, 0);
      send_char(8'h32, 8, 0);
      expect_char(8'h10, 8, 1);
      expect_char(8'h16, 8, 0);
      chk(syn_det == 1, "R8 syn flag without strip", syn_det, 1);
      expect_char(8'h10, 8, 0);
      expect_char(8'h41, 8, 0);
      chk(dle_det == 1, "R8 escape flag without strip", dle_det, 1);
      drain("R8 delivery");

      // R9 jam sync
      restart(0, 0, 0, 1);
      idle(8);
      send_char(8'h16, 8, 0);
      idle(4);
      chk(syn_det == 0, "R9 pattern ignored", syn_det, 0);
      ext_sync = 1'b1; rx_bit = 1'b1;
      @(negedge clk);
      ext_sync = 1'b0;
      chk(syn_det == 1, "R9 strobe sets flag", syn_det, 1);
      expect_char(8'h16, 8, 0);
      expect_char(8'h55, 8, 0);
      chk(syn_det == 1, "R9 flag holds", syn_det, 1);
      expect_char(8'h56, 8, 1);
      chk(syn_det == 0, "R9 read clears", syn_det, 0);
      drain("R9 delivery");

      // R10 five-bit characters, upper register bits ignored
      syn1 = 8'hF6;
      len_sel = 2'd0;
      restart(0, 0, 0, 0);
      idle(7);
      send_char(8'h16, 5, 0);
      chk(syn_det == 1, "R10 short lock", syn_det, 1);
      expect_char(8'h0A, 5, 0);
      expect_char(8'h16, 5, 0);
      drain("R10 delivery");

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule